// File: doc/BRIEF.md
# Multi-Width Compare Flag Unit

The unit compares two operands by subtracting the second from the first and keeps only the six status flags that a subtraction produces. The difference itself is thrown away. Operands arrive on two 64-bit buses. A two-bit size code selects whether the comparison works on 8, 16, 32 or 64 bits. Bits of either bus above the active size play no part in any flag.

The second operand may instead be an immediate of 8, 16 or 32 bits, taken from the low end of the second bus. It is sign-extended to the operand size before the subtraction. This lets a short constant be compared against a wide register. Each size has its own subtractor lane, and the size code picks one lane's flags.

With the default configuration, the flags are registered. A request presented with `in_valid_i` produces its flags and a one-cycle valid strobe on the following clock edge. The flag vector holds its value between requests.

Top module: `cmpf_unit`

## Requirements
- R1: While `rst_n` is low and after reset, `flags_o` is all zero and `flags_valid_o` is low until the first request.
- R2: A request accepted on a rising edge with `in_valid_i` high sets `flags_valid_o` high for exactly the next cycle, with the flags of that request. Without a request `flags_valid_o` is low and `flags_o` keeps its last value.
- R3: `flags_o[0]` (carry) is 1 exactly when the first operand, read as unsigned at the active size, is smaller than the second.
- R4: `flags_o[5]` (overflow) is 1 exactly when the two operands have different signs at the active size and the sign of the difference differs from the sign of the first operand.
- R5: `flags_o[4]` (sign) equals the most significant bit of the difference at the active size.
- R6: `flags_o[3]` (zero) is 1 exactly when every bit of the difference at the active size is zero. When it is set, carry, sign and overflow are all 0.
- R7: `flags_o[2]` (nibble borrow) is 1 exactly when the low four bits of the first operand, read as unsigned, are below those of the second.
- R8: `flags_o[1]` (parity) is 1 when the low byte of the difference has an even number of one bits, for every operand size.
- R9: `op_size_i` codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Operand bits above the selected size do not affect any flag.
- R10: With `imm_en_i` high, `imm_width_i` code 0 takes `opb_i[7:0]`, code 1 takes `opb_i[15:0]`, and codes 2 and 3 take `opb_i[31:0]`. The value is sign-extended to the active size. For example, an 8-bit or 32-bit immediate is extended to match a 64-bit first operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | A compare request is present this cycle |
| opa_i | input | 64 | First operand (minuend) |
| opb_i | input | 64 | Second operand, or the immediate in its low bits |
| op_size_i | input | 2 | Active operand size code |
| imm_en_i | input | 1 | Second operand is an immediate |
| imm_width_i | input | 2 | Immediate width code |
| flags_o | output | 6 | {overflow, sign, zero, nibble borrow, parity, carry} |
| flags_valid_o | output | 1 | Flags of a request are on `flags_o` this cycle |

## Verification
Equal operands at every size separate the zero path from the borrow path. Pairs straddling the sign boundary, such as 0x80 minus 1 at byte size, separate signed overflow from unsigned carry. Nonzero data above the active size on both buses shows whether a lane leaks wide bits into any flag. Negative immediates of each width against wider operands show whether sign extension reaches the top of the active size. A pseudo-random sweep over all four sizes then sets every flag against an arithmetic model built from unsigned and signed comparisons.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    localparam int unsigned NSIZES = 4;
    localparam int unsigned OPW    = 8 << (NSIZES - 1);
    localparam int unsigned SZW    = $clog2(NSIZES);

    typedef enum logic [1:0] {
        IW_8   = 2'd0,
        IW_16  = 2'd1,
        IW_32  = 2'd2,
        IW_32B = 2'd3
    } immw_e;

    // packed MSB first: of=5 sf=4 zf=3 af=2 pf=1 cf=0
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef struct packed {
        flags_t flags;
        logic   vld;
    } out_t;

endpackage

// File: rtl/cmpf_sext.sv
module cmpf_sext
    import cmpf_pkg::*;
(
    input  logic [OPW-1:0] opb,
    input  logic           imm_en,
    input  logic [1:0]     imm_width,
    output logic [OPW-1:0] src2
);
    always_comb begin
        if (!imm_en) begin
            src2 = opb;
        end else begin
            unique case (immw_e'(imm_width))
                IW_8:    src2 = {{(OPW-8){opb[7]}},   opb[7:0]};
                IW_16:   src2 = {{(OPW-16){opb[15]}}, opb[15:0]};
                default: src2 = {{(OPW-32){opb[31]}}, opb[31:0]};
            endcase
        end
    end
endmodule

// File: rtl/cmpf_lane.sv
module cmpf_lane
    import cmpf_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output flags_t       fl
);
    logic [W:0] diff;

    always_comb begin
        diff  = {1'b0, a} - {1'b0, b};
        fl.cf = diff[W];
        fl.sf = diff[W-1];
        fl.zf = ~|diff[W-1:0];
        fl.of = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
        fl.af = a[4] ^ b[4] ^ diff[4];
        fl.pf = ~^diff[7:0];
    end
endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
    import cmpf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid_i,
    input  logic [63:0]    opa_i,
    input  logic [63:0]    opb_i,
    input  logic [1:0]     op_size_i,
    input  logic           imm_en_i,
    input  logic [1:0]     imm_width_i,
    output logic [5:0]     flags_o,
    output logic           flags_valid_o
);
    logic [OPW-1:0] src2;
    flags_t         lane_fl [NSIZES];
    flags_t         flags_comb;
    out_t           out_d, out_q;

    cmpf_sext u_sext (
        .opb       (opb_i),
        .imm_en    (imm_en_i),
        .imm_width (imm_width_i),
        .src2      (src2)
    );

    for (genvar g = 0; g < NSIZES; g++) begin : g_lane
        localparam int unsigned LW = 8 << g;
        cmpf_lane #(.W(LW)) u_lane (
            .a  (opa_i[LW-1:0]),
            .b  (src2[LW-1:0]),
            .fl (lane_fl[g])
        );
    end

    always_comb begin
        flags_comb = lane_fl[op_size_i];
    end

    always_comb begin
        out_d = out_q;
        out_d.vld = in_valid_i;
        if (in_valid_i) begin
            out_d.flags = flags_comb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    if (REG_OUT) begin : g_reg
        assign flags_o       = out_q.flags;
        assign flags_valid_o = out_q.vld;

        // R2
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid_i |=> flags_valid_o);
        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid_i |=> (!flags_valid_o && $stable(flags_o)));
    end else begin : g_comb
        assign flags_o       = in_valid_i ? flags_comb : out_q.flags;
        assign flags_valid_o = in_valid_i;
    end

    // Assertion-side view of the active-size operands
    logic [OPW-1:0] chk_mask, chk_a, chk_b;
    always_comb begin
        chk_mask = {OPW{1'b1}} >> (OPW - (32'd8 << op_size_i));
        chk_a    = opa_i & chk_mask;
        chk_b    = src2 & chk_mask;
    end

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |-> (flags_comb.zf == (chk_a == chk_b)));
    // R3
    carry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |-> (flags_comb.cf == (chk_a < chk_b)));
    // R6
    zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_valid_o && flags_o[3]) |-> (!flags_o[0] && !flags_o[4] && !flags_o[5]));
    // R10
    imm_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && imm_en_i && imm_width_i == 2'd0) |-> (src2[OPW-1:8] == {(OPW-8){opb_i[7]}}));
endmodule

// File: tb/cmpf_unit_tb_top.sv
module cmpf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [1:0]  op_size_i = '0;
    logic        imm_en_i = 1'b0;
    logic [1:0]  imm_width_i = '0;
    logic [5:0]  flags_o;
    logic        flags_valid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmpf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
        .opa_i(opa_i), .opb_i(opb_i), .op_size_i(op_size_i),
        .imm_en_i(imm_en_i), .imm_width_i(imm_width_i),
        .flags_o(flags_o), .flags_valid_o(flags_valid_o)
    );

    function automatic logic [63:0] ext_src(logic [63:0] b, logic en, logic [1:0] w);
        if (!en) return b;
        case (w)
            2'd0:    return {{56{b[7]}}, b[7:0]};
            2'd1:    return {{48{b[15]}}, b[15:0]};
            default: return {{32{b[31]}}, b[31:0]};
        endcase
    endfunction

    function automatic logic [5:0] ref_flags(logic [63:0] a, logic [63:0] b, int n);
        logic [63:0] m, am, bm, d;
        longint sa, sb;
        logic cf, zf, sf, of, af, pf;
        m  = (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
        am = a & m;
        bm = b & m;
        d  = (am - bm) & m;
        cf = (am < bm);
        zf = (am == bm);
        sf = d[n-1];
        sa = longint'(am << (64 - n)) >>> (64 - n);
        sb = longint'(bm << (64 - n)) >>> (64 - n);
        of = ((sa < sb) != sf);
        af = (am[3:0] < bm[3:0]);
        pf = ~^d[7:0];
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request, check flags in the cycle after the accepting edge
    task automatic run_one(string req, logic [63:0] a, logic [63:0] b,
                           logic [1:0] sz, logic en, logic [1:0] w);
        logic [5:0] exp;
        exp = ref_flags(a, ext_src(b, en, w), 8 << sz);
        @(negedge clk);
        opa_i = a; opb_i = b; op_size_i = sz; imm_en_i = en; imm_width_i = w;
        in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        check({req, " valid"}, 64'(flags_valid_o), 64'd1);
        check({req, " flags"}, 64'(flags_o), 64'(exp));
    endtask

    task automatic test_reset();
        check("R1 flags in reset", 64'(flags_o), 64'd0);
        check("R1 valid in reset", 64'(flags_valid_o), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", 64'(flags_o), 64'd0);
        check("R1 valid after reset", 64'(flags_valid_o), 64'd0);
    endtask

    task automatic test_strobe();
        logic [5:0] held;
        run_one("R2 one request", 64'h05, 64'h07, 2'd0, 1'b0, 2'd0);
        held = flags_o;
        opa_i = 64'h1234; opb_i = 64'h1234;
        @(negedge clk);
        check("R2 strobe ends", 64'(flags_valid_o), 64'd0);
        check("R2 flags hold", 64'(flags_o), 64'(held));
        @(negedge clk);
        check("R2 flags still hold", 64'(flags_o), 64'(held));
    endtask

    task automatic test_equal();
        for (int s = 0; s < 4; s++) begin
            run_one("R6 equal", 64'hA5A5_5A5A_0F0F_F0F0, 64'hA5A5_5A5A_0F0F_F0F0, 2'(s), 1'b0, 2'd0);
            check("R6 zero bit", 64'(flags_o[3]), 64'd1);
        end
    endtask

    task automatic test_borrow_overflow();
        run_one("R4 byte overflow", 64'h80, 64'h01, 2'd0, 1'b0, 2'd0);
        check("R4 of set", 64'(flags_o[5]), 64'd1);
        check("R3 no carry", 64'(flags_o[0]), 64'd0);
        run_one("R3 byte borrow", 64'h01, 64'h02, 2'd0, 1'b0, 2'd0);
        check("R3 carry set", 64'(flags_o[0]), 64'd1);
        check("R5 sign set", 64'(flags_o[4]), 64'd1);
        run_one("R4 word overflow", 64'h7FFF, 64'hFFFF, 2'd1, 1'b0, 2'd0);
        check("R4 of word", 64'(flags_o[5]), 64'd1);
        run_one("R5 dword sign", 64'h0, 64'h1, 2'd2, 1'b0, 2'd0);
        check("R5 sign dword", 64'(flags_o[4]), 64'd1);
        run_one("R4 qword overflow", 64'h8000_0000_0000_0000, 64'h1, 2'd3, 1'b0, 2'd0);
        check("R4 of qword", 64'(flags_o[5]), 64'd1);
    endtask

    task automatic test_nibble_parity();
        run_one("R7 nibble borrow", 64'h10, 64'h01, 2'd0, 1'b0, 2'd0);
        check("R7 af set", 64'(flags_o[2]), 64'd1);
        run_one("R7 no nibble borrow", 64'h1F, 64'h01, 2'd0, 1'b0, 2'd0);
        check("R7 af clear", 64'(flags_o[2]), 64'd0);
        run_one("R8 parity qword", 64'h1234_5678_0000_0003, 64'h0, 2'd3, 1'b0, 2'd0);
        check("R8 even low byte", 64'(flags_o[1]), 64'd1);
        run_one("R8 parity word", 64'h0107, 64'h0, 2'd1, 1'b0, 2'd0);
        check("R8 odd low byte", 64'(flags_o[1]), 64'd0);
    endtask

    task automatic test_upper_ignored();
        run_one("R9 byte ignores upper", 64'hDEAD_BEEF_CAFE_0105, 64'h1111_2222_3333_4405, 2'd0, 1'b0, 2'd0);
        check("R9 byte zero", 64'(flags_o), 64'h0A);
        run_one("R9 word ignores upper", 64'hFFFF_FFFF_FFFF_0001, 64'h0000_0000_0000_0002, 2'd1, 1'b0, 2'd0);
        run_one("R9 dword ignores upper", 64'h0000_0001_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd0);
        check("R9 dword of", 64'(flags_o[5]), 64'd1);
    endtask

    task automatic test_immediate();
        run_one("R10 imm8 to qword", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF, 2'd3, 1'b1, 2'd0);
        check("R10 imm8 zero", 64'(flags_o[3]), 64'd1);
        run_one("R10 imm32 to qword", 64'hFFFF_FFFF_8000_0000, 64'h1234_5678_8000_0000, 2'd3, 1'b1, 2'd2);
        check("R10 imm32 zero", 64'(flags_o[3]), 64'd1);
        run_one("R10 imm16 to dword", 64'hFFFF_8001, 64'h0000_8000, 2'd2, 1'b1, 2'd1);
        check("R10 imm16 diff one", 64'(flags_o[3]), 64'd0);
        run_one("R10 imm8 to word", 64'h0000_0000_0000_0000, 64'h80, 2'd1, 1'b1, 2'd0);
        check("R10 imm8 borrow", 64'(flags_o[0]), 64'd1);
        run_one("R10 code3 as 32", 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFE, 2'd3, 1'b1, 2'd3);
        check("R10 code3 zero", 64'(flags_o[3]), 64'd1);
    endtask

    task automatic test_sweep();
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] y;
        for (int i = 0; i < 160; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            y = (i % 5 == 0) ? x : (x * 64'd6364136223846793005 + 64'd1442695040888963407);
            run_one("R3 R4 R5 R6 R7 R8 sweep", x, y, 2'(i % 4), (i % 3 == 0), 2'(i % 4));
        end
    endtask

    initial begin
        test_reset();
        test_strobe();
        test_equal();
        test_borrow_overflow();
        test_nibble_parity();
        test_upper_ignored();
        test_immediate();
        test_sweep();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule